// File: doc/BRIEF.md
# FIFO Loopback Path Controller

This block steers traffic between two queues of a bidirectional buffer pair when a diagnostic loop is switched on. With the loop enabled it pops words from the return-direction queue and pushes them into the forward-direction queue. It also decides whether each popped word is copied onto the shared bidirectional data port. That copy happens only when the port is configured to be read by the outside. In that case the port's output driver is enabled and carries the word.

The controller follows both queues' flags. If the forward queue fills while the port is readable, popping continues and the words go only to the port. If the return queue runs dry, the controller keeps writing the last word it popped into the forward queue on every clock. This repetition lasts until the forward queue is full or the loop is switched off.

Both queues share one clock on this path. The source queue presents its head word whenever it is not empty, in fall-through fashion. Read and write enables are decided from the flags seen at the same edge on which they take effect.

Top module: `fifo_loop_ctrl`

## Requirements
- R1: After reset no word has been captured, so with the loop enabled and the source empty the destination write enable stays 0.
- R2: While `loop_en` is 0, `src_rd_en`, `dst_wr_en` and `port_oe` are all 0 whatever the flags are.
- R3: With `loop_en`=1, source not empty and destination not full, `src_rd_en`=1, `dst_wr_en`=1 and `dst_wr_data` equals `src_data`.
- R4: With `port_rd_mode`=0 (port set for write), `port_oe` is 0 even while words are being looped.
- R5: With `port_rd_mode`=1 (port set for read) and a word being popped, `port_oe`=1 and `port_dout` equals `src_data`.
- R6: With the destination full and `port_rd_mode`=1, popping continues (`src_rd_en`=1, `port_oe`=1) while `dst_wr_en`=0.
- R7: With the destination full and `port_rd_mode`=0, the source is not popped and nothing is written or driven.
- R8: With the source empty after at least one pop since reset, `dst_wr_en`=1 on every cycle the destination is not full. `dst_wr_data` is the last popped word, and `port_oe`=0.
- R9: Each pop replaces the held word, so the repeated word is always the most recently popped one.
- R10: The repetition of R8 stops when `dst_full` rises or `loop_en` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock of the loop path |
| rst_n | input | 1 | Active-low synchronous reset |
| loop_en | input | 1 | Loop mode enable |
| port_rd_mode | input | 1 | 1: shared port set for read (driven), 0: set for write |
| src_empty | input | 1 | Return-direction queue empty flag |
| src_data | input | WORD_W | Head word of the return-direction queue |
| dst_full | input | 1 | Forward-direction queue full flag |
| src_rd_en | output | 1 | Pop strobe to the return-direction queue |
| dst_wr_en | output | 1 | Push strobe to the forward-direction queue |
| dst_wr_data | output | WORD_W | Word pushed into the forward-direction queue |
| port_oe | output | 1 | Output enable of the shared port driver |
| port_dout | output | WORD_W | Word driven onto the shared port |

## Verification
The hardest situation to reach is the dry-source repetition. It needs a pop first, then an empty source, and the repeated word must differ from whatever the source data lines show at that moment. The stimulus pops two distinct words in turn and then raises the empty flag while putting a third, unrelated value on the data lines. Only the second popped word may appear at the destination. The stimulus then toggles the full flag and the loop enable to end the repetition, and applies a fresh reset to show that the held word is forgotten.

// File: rtl/fifo_loop_pkg.sv
package fifo_loop_pkg;

  // Pop the source when it has data and the word has somewhere to go.
  function automatic logic want_pop(input logic loop_on, input logic empty,
                                    input logic full, input logic rd_mode);
    return loop_on & ~empty & (~full | rd_mode);
  endfunction

  // Push the destination when it has room and a fresh or held word exists.
  function automatic logic want_push(input logic loop_on, input logic empty,
                                     input logic full, input logic held);
    return loop_on & ~full & (~empty | held);
  endfunction

endpackage

// File: rtl/fifo_loop_gate.sv
module fifo_loop_gate
  import fifo_loop_pkg::*;
(
  input  logic loop_en,
  input  logic port_rd_mode,
  input  logic src_empty,
  input  logic dst_full,
  input  logic held_valid,
  output logic pop,
  output logic push,
  output logic push_held
);

  always_comb begin
    pop       = want_pop(loop_en, src_empty, dst_full, port_rd_mode);
    push      = want_push(loop_en, src_empty, dst_full, held_valid);
    push_held = push & src_empty;
  end

endmodule

// File: rtl/fifo_loop_hold.sv
module fifo_loop_hold #(
  parameter int WORD_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pop,
  input  logic [WORD_W-1:0] word_in,
  output logic              held_valid,
  output logic [WORD_W-1:0] held_word
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_valid <= 1'b0;
      held_word  <= '0;
    end else if (pop) begin
      held_valid <= 1'b1;
      held_word  <= word_in;
    end
  end

  // Each pop leaves exactly the popped word behind.
  assert_capture_latest_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> (held_valid && held_word == $past(word_in)));

endmodule

// File: rtl/fifo_loop_mirror.sv
module fifo_loop_mirror #(
  parameter int WORD_W = 36
) (
  input  logic              pop,
  input  logic              port_rd_mode,
  input  logic [WORD_W-1:0] word_in,
  output logic              oe,
  output logic [WORD_W-1:0] dout
);

  always_comb begin
    oe   = pop & port_rd_mode;
    dout = oe ? word_in : '0;
  end

endmodule

// File: rtl/fifo_loop_ctrl.sv
module fifo_loop_ctrl #(
  parameter int WORD_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loop_en,
  input  logic              port_rd_mode,
  input  logic              src_empty,
  input  logic [WORD_W-1:0] src_data,
  input  logic              dst_full,
  output logic              src_rd_en,
  output logic              dst_wr_en,
  output logic [WORD_W-1:0] dst_wr_data,
  output logic              port_oe,
  output logic [WORD_W-1:0] port_dout
);

  logic              held_valid;
  logic [WORD_W-1:0] held_word;
  logic              pop_evt;
  logic              push_evt;
  logic              repeat_evt;

  fifo_loop_gate u_gate (
    .loop_en      (loop_en),
    .port_rd_mode (port_rd_mode),
    .src_empty    (src_empty),
    .dst_full     (dst_full),
    .held_valid   (held_valid),
    .pop          (pop_evt),
    .push         (push_evt),
    .push_held    (repeat_evt)
  );

  fifo_loop_hold #(.WORD_W(WORD_W)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .pop        (pop_evt),
    .word_in    (src_data),
    .held_valid (held_valid),
    .held_word  (held_word)
  );

  fifo_loop_mirror #(.WORD_W(WORD_W)) u_mirror (
    .pop          (pop_evt),
    .port_rd_mode (port_rd_mode),
    .word_in      (src_data),
    .oe           (port_oe),
    .dout         (port_dout)
  );

  assign src_rd_en   = pop_evt;
  assign dst_wr_en   = push_evt;
  assign dst_wr_data = repeat_evt ? held_word : src_data;

  assert_idle_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_en |-> (!src_rd_en && !dst_wr_en && !port_oe));

  assert_no_push_into_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dst_full |-> !dst_wr_en);

  assert_port_quiet_write_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !port_rd_mode |-> !port_oe);

  assert_port_only_on_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    port_oe |-> (src_rd_en && port_dout == src_data));

  assert_repeat_last_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
    src_rd_en |=> ((src_empty && dst_wr_en) -> (dst_wr_data == $past(src_data))));

endmodule

// File: tb/fifo_loop_ctrl_test.sv
module fifo_loop_ctrl_test;
  localparam int W = 36;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         loop_en, port_rd_mode, src_empty, dst_full;
  logic [W-1:0] src_data;
  logic         src_rd_en, dst_wr_en, port_oe;
  logic [W-1:0] dst_wr_data, port_dout;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  fifo_loop_ctrl #(.WORD_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .loop_en(loop_en), .port_rd_mode(port_rd_mode),
    .src_empty(src_empty), .src_data(src_data), .dst_full(dst_full),
    .src_rd_en(src_rd_en), .dst_wr_en(dst_wr_en), .dst_wr_data(dst_wr_data),
    .port_oe(port_oe), .port_dout(port_dout)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic le, input logic rm, input logic se,
                       input logic df, input logic [W-1:0] d);
    @(negedge clk);
    loop_en = le; port_rd_mode = rm; src_empty = se; dst_full = df; src_data = d;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    loop_en = 1'b0; port_rd_mode = 1'b0; src_empty = 1'b1; dst_full = 1'b0; src_data = '0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_state();
    do_reset();
    drive(1, 1, 1, 0, 36'h0_1111_2222);
    check("R1 wr_en after reset, source empty", dst_wr_en, 0);
    check("R1 rd_en after reset, source empty", src_rd_en, 0);
  endtask

  task automatic t_loop_off();
    drive(0, 1, 0, 0, 36'h5_A5A5_A5A5);
    check("R2 rd_en off", src_rd_en, 0);
    check("R2 wr_en off", dst_wr_en, 0);
    check("R2 oe off", port_oe, 0);
  endtask

  task automatic t_pass_write_mode();
    drive(1, 0, 0, 0, 36'h9_1234_5678);
    check("R3 rd_en", src_rd_en, 1);
    check("R3 wr_en", dst_wr_en, 1);
    check("R3 wr_data", dst_wr_data, 36'h9_1234_5678);
    check("R4 oe in write mode", port_oe, 0);
  endtask

  task automatic t_pass_read_mode();
    drive(1, 1, 0, 0, 36'h3_CAFE_0001);
    check("R3 wr_data read mode", dst_wr_data, 36'h3_CAFE_0001);
    check("R5 oe", port_oe, 1);
    check("R5 dout", port_dout, 36'h3_CAFE_0001);
  endtask

  task automatic t_full_read_mode();
    drive(1, 1, 0, 1, 36'h7_0000_BEEF);
    check("R6 rd_en continues", src_rd_en, 1);
    check("R6 wr_en off", dst_wr_en, 0);
    check("R6 oe", port_oe, 1);
    check("R6 dout", port_dout, 36'h7_0000_BEEF);
  endtask

  task automatic t_full_write_mode();
    drive(1, 0, 0, 1, 36'h2_2222_2222);
    check("R7 rd_en", src_rd_en, 0);
    check("R7 wr_en", dst_wr_en, 0);
    check("R7 oe", port_oe, 0);
  endtask

  task automatic t_dry_source();
    drive(1, 0, 0, 0, 36'h1_AAAA_0001);
    drive(1, 0, 0, 0, 36'h1_BBBB_0002);
    drive(1, 1, 1, 0, 36'hF_DEAD_DEAD);
    check("R8 wr_en when dry", dst_wr_en, 1);
    check("R9 repeats newest word", dst_wr_data, 36'h1_BBBB_0002);
    check("R8 no pop when dry", src_rd_en, 0);
    check("R8 oe when dry", port_oe, 0);
    drive(1, 1, 1, 0, 36'hF_DEAD_DEAD);
    check("R8 repeat on next cycle", dst_wr_data, 36'h1_BBBB_0002);
    check("R8 wr_en next cycle", dst_wr_en, 1);
    drive(1, 1, 1, 1, 36'hF_DEAD_DEAD);
    check("R10 stops when full", dst_wr_en, 0);
    drive(0, 1, 1, 0, 36'hF_DEAD_DEAD);
    check("R10 stops when loop off", dst_wr_en, 0);
    drive(1, 1, 1, 0, 36'hF_DEAD_DEAD);
    check("R10 resumes with held word", dst_wr_data, 36'h1_BBBB_0002);
    do_reset();
    drive(1, 1, 1, 0, 36'hF_DEAD_DEAD);
    check("R1 held word forgotten by reset", dst_wr_en, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=5000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_loop_off();
    t_pass_write_mode();
    t_pass_read_mode();
    t_full_read_mode();
    t_full_write_mode();
    t_dry_source();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule